// File: doc/BRIEF.md
# Pattern-space bank mapper with automatic tile latch

This block turns each 13-bit pattern fetch address from the picture processor into an address in a character ROM. The 8 KB pattern space is cut into eight 1 KB slots. Each slot is served by one of eight 16-bit bank registers. A size mode groups the slots into one 8 KB window, two 4 KB windows, four 2 KB windows or eight 1 KB windows. An optional outer-block setting narrows each register with a mask that depends on the size mode and adds a fixed block offset above it. A mirror option sends the third and fourth 1 KB slots back to the first two registers.

In the 4 KB mode, each half of pattern space takes its register from a small latch. The latch switches by itself when the picture processor fetches either of two particular tiles in that half. Software can therefore change banks in the middle of a frame without any CPU write. A build parameter removes the latches, and the 4 KB halves then always use registers 0 and 4.

The CPU writes registers through a simple strobe port. The ROM address is combinational from the current fetch address and the stored state. Register and latch updates take effect from the next clock cycle.

Top module: `chr_bank_mapper`

## Requirements
- R1: A write with address bits 15:12 = 9 loads bits 7:0 of bank register (address bits 2:0). A write with bits 15:12 = 0xA loads bits 15:8 of that register. Every bank register resets to 0xFFFF.
- R2: A write with bits 15:12 = 0xD and bits 1:0 = 0 sets the size mode from data bits 4:3: 0 = one 8 KB window, 1 = two 4 KB, 2 = four 2 KB, 3 = eight 1 KB. The size mode resets to 0.
- R3: A write with bits 15:12 = 0xD and bits 1:0 = 3 sets the options. Block mode is on when data bit 5 is 0, and the block number is {data[4], data[3], data[0]}. In block mode the window number is (reg & (0xFF >> (3 − mode))) | (block << (mode + 5)). After reset, block mode is on with block 0.
- R4: When block mode is off, the window number is the full 16-bit register.
- R5: Data bit 7 of the options write sets mirroring. In 1 KB mode, slots 2 and 3 then use registers 0 and 1. In 2 KB mode, the second window then uses register 0.
- R6: Without mirroring, 2 KB mode uses registers 0, 2, 4 and 6, and 8 KB mode uses register 0 alone. The 1 KB slot number is window × (8 >> mode) plus the slot's position inside the window.
- R7: In 4 KB mode, the lower half uses the register named by latch 0 and the upper half uses the register named by latch 1. After reset, the latches are 0 and 4.
- R8: A fetch whose address bits 11:3 equal 0x1FB or 0x1FD sets the latch of the half given by address bit 12 to (address >> 4) & ((bit12 << 2) | 2). This gives 0 or 2 for the lower half and 4 or 6 for the upper half. The change applies from the next fetch, not to the fetch that triggered it.
- R9: With LATCH_EN = 0, the 4 KB mode always uses registers 0 and 4, whatever tiles are fetched.
- R10: The output address is ((1 KB slot) mod CHR_KB) × 1024 + fetch address bits 9:0.
- R11: Fetches of other tiles leave the latches unchanged. Writes to pages other than 9, 0xA and 0xD, and 0xD writes with address bits 1:0 equal to 1 or 2, leave the output mapping unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | CPU write strobe, one write per cycle |
| wr_addr | input | 16 | CPU write address |
| wr_data | input | 8 | CPU write data |
| ppu_rd | input | 1 | Pattern fetch strobe; triggers latch updates |
| ppu_addr | input | 13 | Pattern fetch address |
| chr_addr | output | log2(CHR_KB)+10 | Character ROM byte address |

## Verification
The hardest case to reach is a latch switch observed from the ports. It shows only while the 4 KB mode is active, and only when the register the latch names holds a different value from the one it replaces. The one-fetch delay also needs the triggering fetch and the next fetch to land in consecutive checks. The stimulus loads all eight registers with distinct values and selects the 4 KB mode. It then fetches each trigger tile followed by a plain fetch in the same half, and checks both the old selection on the trigger and the new one after it. A second instance built without latches runs on the same inputs. Random stimulus mixes register writes with fetches biased toward the trigger tiles.

// File: rtl/chr_map_pkg.sv
package chr_map_pkg;

    localparam int REG_N = 8;
    localparam int REG_W = 16;
    localparam int SEL_W = $clog2(REG_N);
    localparam int IDX_W = REG_W + 3;

    localparam logic [3:0] PG_LOW  = 4'h9;
    localparam logic [3:0] PG_HIGH = 4'hA;
    localparam logic [3:0] PG_CTRL = 4'hD;
    localparam logic [1:0] SUB_SIZE = 2'd0;
    localparam logic [1:0] SUB_OPT  = 2'd3;

    localparam logic [8:0] TILE_A = 9'h1FB;
    localparam logic [8:0] TILE_B = 9'h1FD;

    localparam logic [SEL_W-1:0] LATCH0_RST = 3'd0;
    localparam logic [SEL_W-1:0] LATCH1_RST = 3'd4;

    typedef enum logic [1:0] {
        SZ_8K = 2'd0,
        SZ_4K = 2'd1,
        SZ_2K = 2'd2,
        SZ_1K = 2'd3
    } chr_size_e;

    typedef struct packed {
        chr_size_e  size;
        logic       mirror;
        logic       blk_on;
        logic [2:0] blk;
    } chr_ctrl_t;

    localparam chr_ctrl_t CTRL_RST = '{size: SZ_8K, mirror: 1'b0, blk_on: 1'b1, blk: 3'd0};

    // Register feeding a 1 KB slot under the current size and mirror setting.
    function automatic logic [SEL_W-1:0] pick_reg(
        input chr_size_e        sz,
        input logic [2:0]       slot,
        input logic             mir,
        input logic [SEL_W-1:0] lat0,
        input logic [SEL_W-1:0] lat1
    );
        logic [SEL_W-1:0] r;
        case (sz)
            SZ_8K:   r = 3'd0;
            SZ_4K:   r = slot[2] ? lat1 : lat0;
            SZ_2K:   r = (mir && slot[2:1] == 2'd1) ? 3'd0 : {slot[2:1], 1'b0};
            default: r = (mir && slot[2:1] == 2'd1) ? {2'b00, slot[0]} : slot;
        endcase
        return r;
    endfunction

    // 1 KB slot index before the ROM-size mask.
    function automatic logic [IDX_W-1:0] slot_index(
        input chr_ctrl_t        c,
        input logic [REG_W-1:0] r,
        input logic [2:0]       slot
    );
        logic [1:0]       sh;
        logic [REG_W-1:0] msk;
        logic [IDX_W-1:0] off;
        logic [IDX_W-1:0] win;
        logic [3:0]       span;
        logic [2:0]       low;
        sh   = 2'd3 - c.size;
        msk  = c.blk_on ? (16'h00FF >> sh) : 16'hFFFF;
        off  = c.blk_on ? ({{(IDX_W-3){1'b0}}, c.blk} << ({2'b00, c.size} + 4'd5)) : '0;
        win  = ({3'b000, r & msk} | off) << sh;
        span = (4'd1 << sh) - 4'd1;
        low  = slot & span[2:0];
        return win | {{(IDX_W-3){1'b0}}, low};
    endfunction

endpackage

// File: rtl/chr_bank_regs.sv
module chr_bank_regs
    import chr_map_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_lo,
    input  logic                 wr_hi,
    input  logic [SEL_W-1:0]     idx,
    input  logic [7:0]           data,
    output logic [REG_W-1:0]     regs [REG_N]
);

    for (genvar g = 0; g < REG_N; g++) begin : g_reg
        logic [REG_W-1:0] q;
        logic             hit;

        assign hit = (idx == SEL_W'(g));

        always_ff @(posedge clk) begin
            if (rst) begin
                q <= '1;
            end else if (hit) begin
                if (wr_lo) q[7:0]       <= data;
                if (wr_hi) q[REG_W-1:8] <= data;
            end
        end

        assign regs[g] = q;
    end

endmodule

// File: rtl/chr_ctrl_reg.sv
module chr_ctrl_reg
    import chr_map_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_size,
    input  logic       wr_opt,
    input  logic [7:0] data,
    output chr_ctrl_t  ctrl
);

    logic unused_data;
    assign unused_data = ^{data[6], data[2:1]};

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= CTRL_RST;
        end else begin
            if (wr_size) begin
                ctrl.size <= chr_size_e'(data[4:3]);
            end
            if (wr_opt) begin
                ctrl.mirror <= data[7];
                ctrl.blk_on <= ~data[5];
                ctrl.blk    <= {data[4], data[3], data[0]};
            end
        end
    end

endmodule

// File: rtl/chr_tile_latch.sv
module chr_tile_latch
    import chr_map_pkg::*;
#(
    parameter bit LATCH_EN = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fetch,
    input  logic [12:0]      addr,
    output logic [SEL_W-1:0] lat0,
    output logic [SEL_W-1:0] lat1
);

    if (LATCH_EN) begin : g_on
        logic             hit;
        logic [SEL_W-1:0] nv;
        logic             unused_bits;

        assign unused_bits = ^{addr[2:0]};
        assign hit = fetch && (addr[11:3] == TILE_A || addr[11:3] == TILE_B);
        assign nv  = {addr[12] & addr[6], addr[5], 1'b0};

        always_ff @(posedge clk) begin
            if (rst) begin
                lat0 <= LATCH0_RST;
                lat1 <= LATCH1_RST;
            end else if (hit) begin
                if (addr[12]) lat1 <= nv;
                else          lat0 <= nv;
            end
        end
    end else begin : g_off
        logic unused_in;
        assign unused_in = ^{clk, rst, fetch, addr};
        assign lat0 = LATCH0_RST;
        assign lat1 = LATCH1_RST;
    end

endmodule

// File: rtl/chr_bank_mapper.sv
module chr_bank_mapper
    import chr_map_pkg::*;
#(
    parameter int CHR_KB   = 2048,
    parameter bit LATCH_EN = 1'b1
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        wr_en,
    input  logic [15:0]                 wr_addr,
    input  logic [7:0]                  wr_data,
    input  logic                        ppu_rd,
    input  logic [12:0]                 ppu_addr,
    output logic [$clog2(CHR_KB)+9:0]   chr_addr
);

    localparam int BANK_W = $clog2(CHR_KB);

    logic [3:0]        page;
    logic              wr_lo, wr_hi, wr_size, wr_opt;
    logic [REG_W-1:0]  regs [REG_N];
    chr_ctrl_t         ctrl;
    logic [SEL_W-1:0]  lat0, lat1;
    logic [2:0]        slot;
    logic [SEL_W-1:0]  rsel;
    logic [IDX_W-1:0]  idx_full;
    logic              unused_top;

    assign page    = wr_addr[15:12];
    assign wr_lo   = wr_en && page == PG_LOW;
    assign wr_hi   = wr_en && page == PG_HIGH;
    assign wr_size = wr_en && page == PG_CTRL && wr_addr[1:0] == SUB_SIZE;
    assign wr_opt  = wr_en && page == PG_CTRL && wr_addr[1:0] == SUB_OPT;

    chr_bank_regs u_regs (
        .clk   (clk),
        .rst   (rst),
        .wr_lo (wr_lo),
        .wr_hi (wr_hi),
        .idx   (wr_addr[2:0]),
        .data  (wr_data),
        .regs  (regs)
    );

    chr_ctrl_reg u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .wr_size (wr_size),
        .wr_opt  (wr_opt),
        .data    (wr_data),
        .ctrl    (ctrl)
    );

    chr_tile_latch #(.LATCH_EN(LATCH_EN)) u_latch (
        .clk   (clk),
        .rst   (rst),
        .fetch (ppu_rd),
        .addr  (ppu_addr),
        .lat0  (lat0),
        .lat1  (lat1)
    );

    assign slot     = ppu_addr[12:10];
    assign rsel     = pick_reg(ctrl.size, slot, ctrl.mirror, lat0, lat1);
    assign idx_full = slot_index(ctrl, regs[rsel], slot);
    assign chr_addr = {idx_full[BANK_W-1:0], ppu_addr[9:0]};

    assign unused_top = ^{idx_full[IDX_W-1:BANK_W], wr_addr[11:3]};

endmodule

// File: rtl/chr_bank_mapper_chk.sv
module chr_bank_mapper_chk
    import chr_map_pkg::*;
#(
    parameter int CHR_KB   = 2048,
    parameter bit LATCH_EN = 1'b1
) (
    input logic                      clk,
    input logic                      rst,
    input logic                      wr_en,
    input logic [15:0]               wr_addr,
    input logic [7:0]                wr_data,
    input logic                      ppu_rd,
    input logic [12:0]               ppu_addr,
    input logic [$clog2(CHR_KB)+9:0] chr_addr,
    input logic [REG_W-1:0]          regs [REG_N],
    input chr_ctrl_t                 ctrl,
    input logic [SEL_W-1:0]          lat0,
    input logic [SEL_W-1:0]          lat1
);

    for (genvar g = 0; g < REG_N; g++) begin : g_rw
        assert_lo_byte_R1: assert property (@(posedge clk) disable iff (rst)
            (wr_en && wr_addr[15:12] == PG_LOW && wr_addr[2:0] == 3'(g))
            |=> (regs[g][7:0] == $past(wr_data) && regs[g][15:8] == $past(regs[g][15:8])));

        assert_hi_byte_R1: assert property (@(posedge clk) disable iff (rst)
            (wr_en && wr_addr[15:12] == PG_HIGH && wr_addr[2:0] == 3'(g))
            |=> (regs[g][15:8] == $past(wr_data) && regs[g][7:0] == $past(regs[g][7:0])));
    end

    assert_size_load_R2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr[15:12] == PG_CTRL && wr_addr[1:0] == SUB_SIZE)
        |=> (ctrl.size == chr_size_e'($past(wr_data[4:3]))));

    assert_whole_window_R6: assert property (@(posedge clk) disable iff (rst)
        (ctrl.size == SZ_8K) |-> (chr_addr[12:10] == ppu_addr[12:10]));

    assert_latch_legal_R8: assert property (@(posedge clk) disable iff (rst)
        ((lat0 == 3'd0 || lat0 == 3'd2) && (lat1 == 3'd4 || lat1 == 3'd6)));

    assert_latch_idle_R11: assert property (@(posedge clk) disable iff (rst)
        (!ppu_rd) |=> ($stable(lat0) && $stable(lat1)));

    assert_offset_pass_R10: assert property (@(posedge clk) disable iff (rst)
        (chr_addr[9:0] == ppu_addr[9:0]));

    if (!LATCH_EN) begin : g_fixed
        assert_latch_fixed_R9: assert property (@(posedge clk) disable iff (rst)
            (lat0 == 3'd0 && lat1 == 3'd4));
    end

endmodule

bind chr_bank_mapper chr_bank_mapper_chk #(.CHR_KB(CHR_KB), .LATCH_EN(LATCH_EN)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .ppu_rd   (ppu_rd),
    .ppu_addr (ppu_addr),
    .chr_addr (chr_addr),
    .regs     (regs),
    .ctrl     (ctrl),
    .lat0     (lat0),
    .lat1     (lat1)
);

// File: tb/chr_bank_mapper_test.sv
`timescale 1ns/1ps
module chr_bank_mapper_test;

    localparam int KB = 2048;
    localparam int AW = $clog2(KB) + 10;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic [15:0]   wr_addr = '0;
    logic [7:0]    wr_data = '0;
    logic          ppu_rd = 1'b0;
    logic [12:0]   ppu_addr = '0;
    logic [AW-1:0] chr_addr, chr_addr_nl;

    int n_tests = 0;
    int n_fail  = 0;

    int  mreg [8];
    int  mmode, mblk, ml0, ml1;
    bit  mmir, mblk_on;

    always #2.5 clk = ~clk;

    chr_bank_mapper #(.CHR_KB(KB), .LATCH_EN(1'b1)) uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .ppu_rd(ppu_rd), .ppu_addr(ppu_addr), .chr_addr(chr_addr)
    );

    chr_bank_mapper #(.CHR_KB(KB), .LATCH_EN(1'b0)) uut_nl (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .ppu_rd(ppu_rd), .ppu_addr(ppu_addr), .chr_addr(chr_addr_nl)
    );

    task automatic model_reset();
        for (int i = 0; i < 8; i++) mreg[i] = 'hFFFF;
        mmode = 0; mblk = 0; mmir = 0; mblk_on = 1; ml0 = 0; ml1 = 4;
    endtask

    function automatic int exp_addr(int a, bit nl);
        int slot, ri, msk, off, sel, span, bank;
        slot = (a >> 10) & 7;
        span = 8 >> mmode;
        case (mmode)
            0: ri = 0;
            1: ri = (slot < 4) ? (nl ? 0 : ml0) : (nl ? 4 : ml1);
            2: begin ri = (slot / 2) * 2; if (ri == 2 && mmir) ri = 0; end
            default: begin ri = slot; if (mmir && (slot == 2 || slot == 3)) ri = slot - 2; end
        endcase
        if (mblk_on) begin
            case (mmode)
                0: msk = 'h1F;
                1: msk = 'h3F;
                2: msk = 'h7F;
                default: msk = 'hFF;
            endcase
            off = mblk * (32 << mmode);
        end else begin
            msk = 'hFFFF;
            off = 0;
        end
        sel  = (mreg[ri] & msk) | off;
        bank = (sel * span + slot % span) % KB;
        return bank * 1024 + (a & 'h3FF);
    endfunction

    task automatic check(string tag, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cpu_wr(int a, int d);
        int pg, i;
        @(negedge clk);
        ppu_rd  = 1'b0;
        wr_en   = 1'b1;
        wr_addr = a[15:0];
        wr_data = d[7:0];
        @(posedge clk);
        pg = (a >> 12) & 'hF;
        i  = a & 7;
        if (pg == 9) mreg[i] = (mreg[i] & 'hFF00) | (d & 'hFF);
        else if (pg == 'hA) mreg[i] = (mreg[i] & 'hFF) | ((d & 'hFF) << 8);
        else if (pg == 'hD && (a & 3) == 0) mmode = (d >> 3) & 3;
        else if (pg == 'hD && (a & 3) == 3) begin
            mmir    = d[7];
            mblk_on = !d[5];
            mblk    = ((d >> 2) & 6) | (d & 1);
        end
    endtask

    task automatic fetch(string tag, int a);
        int tile, side, v;
        @(negedge clk);
        wr_en    = 1'b0;
        ppu_rd   = 1'b1;
        ppu_addr = a[12:0];
        #1;
        check(tag, int'(chr_addr), exp_addr(a, 1'b0));
        check("R9", int'(chr_addr_nl), exp_addr(a, 1'b1));
        @(posedge clk);
        tile = (a >> 3) & 'h1FF;
        if (tile == 'h1FB || tile == 'h1FD) begin
            side = (a >> 12) & 1;
            v = (a >> 4) & ((side << 2) | 2);
            if (side == 1) ml1 = v; else ml0 = v;
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : main
        int seed_dummy, a, pg;
        seed_dummy = $urandom(32'd2024);
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // Reset state: registers all ones, 8 KB window, block 0 on
        fetch("R1", 'h0000);
        fetch("R2", 'h1C05);
        fetch("R3", 'h0A33);

        // Full 16-bit registers, 1 KB mode, block mode off
        cpu_wr('hD003, 'h20);
        cpu_wr('hD000, 'h18);
        for (int i = 0; i < 8; i++) begin
            cpu_wr('h9000 + i, i * 37 + 5);
            cpu_wr('hA000 + i, i + 1);
        end
        for (int s = 0; s < 8; s++) fetch("R4", s * 1024 + s * 13);
        cpu_wr('hA004, 'h13);
        fetch("R1", 'h1000);

        // Block mode with block 5 across all sizes
        cpu_wr('hD007, 'h11);
        for (int m = 0; m < 4; m++) begin
            cpu_wr('hD004, m << 3);
            for (int s = 0; s < 8; s += 3) fetch("R3", s * 1024 + 7);
        end

        // Mirroring in 1 KB and 2 KB modes, block off
        cpu_wr('hD003, 'hA0);
        cpu_wr('hD000, 'h18);
        for (int s = 0; s < 8; s++) fetch("R5", s * 1024);
        cpu_wr('hD000, 'h10);
        for (int s = 0; s < 8; s++) fetch("R5", s * 1024 + 1);

        // No mirroring: 2 KB and 8 KB register use
        cpu_wr('hD003, 'h20);
        for (int s = 0; s < 8; s++) fetch("R6", s * 1024 + 2);
        cpu_wr('hD000, 'h00);
        for (int s = 0; s < 8; s++) fetch("R6", s * 1024 + 3);

        // 4 KB mode and latch switching, with the one-fetch delay
        cpu_wr('hD000, 'h08);
        fetch("R7", 'h0100);
        fetch("R7", 'h1100);
        fetch("R8", 'h0FE8);
        fetch("R8", 'h0000);
        fetch("R8", 'h1FEC);
        fetch("R8", 'h1000);
        fetch("R8", 'h0FDF);
        fetch("R8", 'h0200);
        fetch("R8", 'h1FD8);
        fetch("R8", 'h1400);
        fetch("R8", 'h0FE8);
        fetch("R11", 'h0FF8);
        fetch("R11", 'h0FC8);
        fetch("R11", 'h0300);

        // Ignored writes
        cpu_wr('hB000, 'h55);
        cpu_wr('hD001, 'hFF);
        cpu_wr('hD002, 'h18);
        cpu_wr('hC005, 'hAA);
        fetch("R11", 'h0000);
        fetch("R11", 'h1800);

        // ROM-size mask
        cpu_wr('hD000, 'h18);
        cpu_wr('h9006, 'hFF);
        cpu_wr('hA006, 'hFF);
        fetch("R10", 'h1BFF);

        // Random mix
        for (int k = 0; k < 400; k++) begin
            if ($urandom % 3 == 0) begin
                case ($urandom % 5)
                    0: pg = 9;
                    1: pg = 'hA;
                    2: pg = 'hD;
                    3: pg = 'hB;
                    default: pg = 'hC;
                endcase
                cpu_wr((pg << 12) | ($urandom % 8), $urandom % 256);
            end else begin
                a = $urandom % 8192;
                if ($urandom % 4 == 0)
                    a = (($urandom % 2) * 'h1000) | (($urandom % 2) ? 'hFD8 : 'hFE8) | ($urandom % 8);
                fetch("R10", a);
            end
        end

        @(negedge clk);
        ppu_rd = 1'b0;
        wr_en  = 1'b0;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule